// File: doc/BRIEF.md
# Stereo Serial Audio Frame Receiver

This block takes a three-wire stereo audio stream (bit clock, word select, serial data) and turns it into left/right sample pairs held in an on-block FIFO. The external bit clock and word select are oversampled by the system clock, so the block never needs a clock of its own from the audio side. Each sample is shifted in most significant bit first on a rising bit-clock edge. A sample starts one bit after a word-select change, and word select low means the left channel.

Software, or a controller next to the block, pulses `rx_start` and the receiver engages at the next frame boundary. From then on every frame with both channels present is pushed into the FIFO as one pair, left entry first. A frame is stored only when two FIFO slots are free. When they are not, both channels are discarded and a sticky overflow flag is raised, so a left sample can never be paired with the wrong right sample. `rx_stop` lets the frame in progress complete before the receiver disengages. While the receiver is disengaged, a FIFO clear request empties the storage.

Top module: `i2s_frame_rx`

## Requirements
- R1: After reset, `rx_busy`, `rd_valid`, `ovf_flag` and `ovf_irq` are all 0.
- R2: Each word is captured MSB first on bit-clock rising edges. The bit sampled on the edge where word select has changed is the LSB of the preceding word. Word select 0 marks left and 1 marks right. A pair is read out left first with `rd_right`=0, then right with `rd_right`=1.
- R3: After a start pulse, `rx_busy` rises only at the next right-to-left word-select change. The frame that begins there is the first one stored. A frame already in progress when start arrives is not stored.
- R4: A completed frame is pushed only when at least two FIFO entries are free, and its two channels are then written together.
- R5: A completed frame that finds fewer than two free entries is dropped whole and sets `ovf_flag`. The flag holds until cleared.
- R6: `ovf_irq` is `ovf_flag` gated by `ovf_mask`. A further overflow while the flag is already set gives no new rising edge on `ovf_irq`.
- R7: A one-cycle `ovf_clr` pulse clears `ovf_flag`. Once reads have freed two entries, the next complete frame is stored again.
- R8: A stop pulse during a frame lets that frame complete and be stored. `rx_busy` then falls at that frame's end, and later frames are not stored.
- R9: While the receiver is not engaged, serial input never reaches the FIFO.
- R10: `rx_fifo_clr` empties the FIFO when the receiver is idle. It has no effect while the receiver is engaged or armed.
- R11: `rd_pop` with `rd_valid` low leaves the FIFO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| i2s_sck | input | 1 | Serial bit clock (asynchronous, oversampled) |
| i2s_ws | input | 1 | Word select, 0 = left channel |
| i2s_sd | input | 1 | Serial data, MSB first |
| rx_start | input | 1 | Pulse: arm receiver for the next frame boundary |
| rx_stop | input | 1 | Pulse: finish current frame, then disengage |
| rx_fifo_clr | input | 1 | Pulse: empty FIFO (honoured only when idle) |
| ovf_clr | input | 1 | Pulse: clear overflow flag |
| ovf_mask | input | 1 | 1 suppresses the overflow interrupt |
| rx_busy | output | 1 | Receiver engaged |
| ovf_flag | output | 1 | Sticky overflow event |
| ovf_irq | output | 1 | Overflow interrupt |
| rd_valid | output | 1 | FIFO head holds a sample |
| rd_data | output | DATA_W | Sample at FIFO head |
| rd_right | output | 1 | Head sample belongs to the right channel |
| rd_pop | input | 1 | Remove head sample |

## Verification
The bench builds the block with DATA_W=8, FIFO_DEPTH=4 and SYNC_STAGES=2. A frame then lasts only sixteen bit periods, and two stored frames fill the FIFO. Overflow, interrupt masking, recovery after a partial drain and the stop-at-frame-end behaviour therefore all occur within a handful of frames. With that shallow depth the bench can also tell a whole-frame drop from a half-written pair after one read.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/1ps
package i2s_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_ARMED = 2'd1,
        RX_RUN   = 2'd2
    } rx_state_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/i2s_rx_sync.sv
`timescale 1ns/1ps
module i2s_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic bit_stb,
    output logic ws_q,
    output logic sd_q
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] ws_p;
    logic [STAGES-1:0] sd_p;
    logic              sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p    <= '0;
            ws_p     <= '0;
            sd_p     <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sck_in};
            ws_p     <= {ws_p[STAGES-2:0], ws_in};
            sd_p     <= {sd_p[STAGES-2:0], sd_in};
            sck_last <= sck_p[STAGES-1];
        end
    end

    assign bit_stb = sck_p[STAGES-1] & ~sck_last;
    assign ws_q    = ws_p[STAGES-1];
    assign sd_q    = sd_p[STAGES-1];
endmodule

// File: rtl/i2s_rx_deser.sv
`timescale 1ns/1ps
module i2s_rx_deser
    import i2s_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              ws_q,
    input  logic              sd_q,
    output logic              word_stb,
    output chan_e             word_chan,
    output logic [DATA_W-1:0] word_data
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

    logic              ws_prev;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] acc_nx;
    logic [CNT_W-1:0]  cnt;
    logic              full;
    logic              turn;

    always_comb begin
        full   = (cnt >= CNT_FULL);
        acc_nx = full ? acc : {acc[DATA_W-2:0], sd_q};
        turn   = bit_stb && (ws_q != ws_prev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_prev   <= 1'b0;
            acc       <= '0;
            cnt       <= '0;
            word_stb  <= 1'b0;
            word_chan <= CH_LEFT;
            word_data <= '0;
        end else begin
            word_stb <= turn;
            if (turn) begin
                word_data <= acc_nx;
                word_chan <= ws_prev ? CH_RIGHT : CH_LEFT;
            end
            if (bit_stb) begin
                ws_prev <= ws_q;
                if (turn) begin
                    acc <= '0;
                    cnt <= '0;
                end else begin
                    acc <= acc_nx;
                    if (!full) cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/i2s_rx_ctrl.sv
`timescale 1ns/1ps
module i2s_rx_ctrl
    import i2s_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              word_stb,
    input  chan_e             word_chan,
    input  logic [DATA_W-1:0] word_data,
    input  logic              room2,
    input  logic              ovf_clr,
    output logic              push,
    output logic [DATA_W-1:0] push_left,
    output logic [DATA_W-1:0] push_right,
    output logic              busy,
    output logic              idle,
    output logic              ovf_flag
);
    rx_state_e         state;
    logic              stop_pend;
    logic              have_left;
    logic [DATA_W-1:0] left_q;
    logic              left_done;
    logic              right_done;
    logic              commit;
    logic              ovf_set;

    always_comb begin
        left_done  = word_stb && (word_chan == CH_LEFT);
        right_done = word_stb && (word_chan == CH_RIGHT);
        commit     = (state == RX_RUN) && right_done && have_left;
        push       = commit && room2;
        ovf_set    = commit && !room2;
        push_left  = left_q;
        push_right = word_data;
        busy       = (state == RX_RUN);
        idle       = (state == RX_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            stop_pend <= 1'b0;
            have_left <= 1'b0;
            left_q    <= '0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    stop_pend <= 1'b0;
                    if (start && !stop) state <= RX_ARMED;
                end
                RX_ARMED: begin
                    have_left <= 1'b0;
                    if (stop)            state <= RX_IDLE;
                    else if (right_done) state <= RX_RUN;
                end
                RX_RUN: begin
                    if (stop) stop_pend <= 1'b1;
                    if (left_done) begin
                        have_left <= 1'b1;
                        left_q    <= word_data;
                    end
                    if (right_done) begin
                        have_left <= 1'b0;
                        if (stop || stop_pend) begin
                            state     <= RX_IDLE;
                            stop_pend <= 1'b0;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_flag <= 1'b0;
        else if (ovf_set) ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/i2s_rx_fifo.sv
`timescale 1ns/1ps
module i2s_rx_fifo
    import i2s_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_left,
    input  logic [DATA_W-1:0] push_right,
    input  logic              pop,
    output logic              room2,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output chan_e             rd_chan
);
    localparam int unsigned AW = ptr_bits(DEPTH);
    localparam logic [AW:0] ROOM_LIM = (AW+1)'(DEPTH - 2);

    typedef struct packed {
        chan_e             ch;
        logic [DATA_W-1:0] d;
    } slot_t;

    slot_t          mem [DEPTH];
    logic [AW:0]    wptr;
    logic [AW:0]    rptr;
    logic [AW:0]    count;
    logic [AW-1:0]  w_lo;
    logic [AW-1:0]  w_hi;
    logic           pop_ok;
    slot_t          head;

    always_comb begin
        count    = wptr - rptr;
        room2    = (count <= ROOM_LIM);
        rd_valid = (count != '0);
        pop_ok   = pop && rd_valid;
        w_lo     = wptr[AW-1:0];
        w_hi     = wptr[AW-1:0] + AW'(1);
        head     = mem[rptr[AW-1:0]];
        rd_data  = head.d;
        rd_chan  = head.ch;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (w_lo == AW'(k))      mem[k] <= '{ch: CH_LEFT,  d: push_left};
                else if (w_hi == AW'(k)) mem[k] <= '{ch: CH_RIGHT, d: push_right};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push)   wptr <= wptr + (AW+1)'(2);
            if (pop_ok) rptr <= rptr + (AW+1)'(1);
        end
    end
endmodule

// File: rtl/i2s_frame_rx.sv
`timescale 1ns/1ps
module i2s_frame_rx
    import i2s_rx_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned FIFO_DEPTH  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i2s_sck,
    input  logic              i2s_ws,
    input  logic              i2s_sd,
    input  logic              rx_start,
    input  logic              rx_stop,
    input  logic              rx_fifo_clr,
    input  logic              ovf_clr,
    input  logic              ovf_mask,
    output logic              rx_busy,
    output logic              ovf_flag,
    output logic              ovf_irq,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_right,
    input  logic              rd_pop
);
    logic              bit_stb;
    logic              ws_q;
    logic              sd_q;
    logic              word_stb;
    chan_e             word_chan;
    logic [DATA_W-1:0] word_data;
    logic              room2;
    logic              push_pair;
    logic [DATA_W-1:0] push_left;
    logic [DATA_W-1:0] push_right;
    logic              rx_idle;
    logic              clr_ok;
    chan_e             head_chan;

    i2s_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sck_in(i2s_sck), .ws_in(i2s_ws), .sd_in(i2s_sd),
        .bit_stb(bit_stb), .ws_q(ws_q), .sd_q(sd_q)
    );

    i2s_rx_deser #(.DATA_W(DATA_W)) u_deser (
        .clk(clk), .rst(rst),
        .bit_stb(bit_stb), .ws_q(ws_q), .sd_q(sd_q),
        .word_stb(word_stb), .word_chan(word_chan), .word_data(word_data)
    );

    i2s_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .start(rx_start), .stop(rx_stop),
        .word_stb(word_stb), .word_chan(word_chan), .word_data(word_data),
        .room2(room2), .ovf_clr(ovf_clr),
        .push(push_pair), .push_left(push_left), .push_right(push_right),
        .busy(rx_busy), .idle(rx_idle), .ovf_flag(ovf_flag)
    );

    assign clr_ok = rx_fifo_clr && rx_idle;

    i2s_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clr(clr_ok),
        .push(push_pair), .push_left(push_left), .push_right(push_right),
        .pop(rd_pop), .room2(room2),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_chan(head_chan)
    );

    assign rd_right = (head_chan == CH_RIGHT);
    assign ovf_irq  = ovf_flag & ~ovf_mask;
endmodule

// File: rtl/i2s_frame_rx_chk.sv
`timescale 1ns/1ps
module i2s_frame_rx_chk (
    input logic clk,
    input logic rst,
    input logic push,
    input logic room2,
    input logic busy,
    input logic idle,
    input logic word_stb,
    input logic ovf_flag,
    input logic ovf_clr,
    input logic ovf_mask,
    input logic ovf_irq,
    input logic clr_req,
    input logic rd_valid,
    input logic rd_pop
);
    // R4
    push_room_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> room2);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ovf_flag) && !ovf_mask) |-> ovf_irq);

    // R9
    push_engaged_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> busy);

    // R10
    clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && idle) |=> !rd_valid);

    // R3
    busy_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(word_stb));

    // R11
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !rd_valid && !push) |=> !rd_valid);
endmodule

bind i2s_frame_rx i2s_frame_rx_chk u_chk (
    .clk(clk), .rst(rst), .push(push_pair), .room2(room2),
    .busy(rx_busy), .idle(rx_idle), .word_stb(word_stb),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .ovf_mask(ovf_mask),
    .ovf_irq(ovf_irq), .clr_req(rx_fifo_clr), .rd_valid(rd_valid),
    .rd_pop(rd_pop)
);

// File: tb/i2s_frame_rx_test.sv
`timescale 1ns/1ps
module i2s_frame_rx_test;
    localparam int W = 8;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic start = 1'b0, stop = 1'b0, fclr = 1'b0, oclr = 1'b0, mask = 1'b0;
    logic pop = 1'b0;
    logic busy, oflag, irq, rvalid, rright;
    logic [W-1:0] rdata;

    int checks = 0;
    int fails  = 0;
    int irq_rises = 0;
    logic irq_prev = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    i2s_frame_rx #(.DATA_W(W), .FIFO_DEPTH(D), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .i2s_sck(sck), .i2s_ws(ws), .i2s_sd(sd),
        .rx_start(start), .rx_stop(stop), .rx_fifo_clr(fclr),
        .ovf_clr(oclr), .ovf_mask(mask), .rx_busy(busy), .ovf_flag(oflag),
        .ovf_irq(irq), .rd_valid(rvalid), .rd_data(rdata), .rd_right(rright),
        .rd_pop(pop)
    );

    always @(negedge clk) begin
        if (!rst && irq && !irq_prev) irq_rises++;
        irq_prev <= irq;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic w, input logic d);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = d;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [W-1:0] l, input logic [W-1:0] r,
                              input bit stop_mid);
        for (int i = W-1; i >= 0; i--) put_bit((i == 0), l[i]);
        if (stop_mid) begin
            @(negedge clk); stop = 1'b1;
            @(negedge clk); stop = 1'b0;
        end
        for (int i = W-1; i >= 0; i--) put_bit((i != 0), r[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_oclr();
        @(negedge clk); oclr = 1'b1; @(negedge clk); oclr = 1'b0;
    endtask

    task automatic pulse_fclr();
        @(negedge clk); fclr = 1'b1; @(negedge clk); fclr = 1'b0;
    endtask

    task automatic pop_expect(input string req, input int exp_d, input bit exp_r);
        @(negedge clk);
        chk({req, " valid"}, rvalid, 1);
        chk({req, " data"}, rdata, exp_d);
        chk({req, " side"}, rright, exp_r);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 rd_valid", rvalid, 0);
        chk("R1 ovf_flag", oflag, 0);
        chk("R1 ovf_irq", irq, 0);
    endtask

    task automatic t_idle();
        send_frame(8'h12, 8'h34, 0);
        send_frame(8'h56, 8'h78, 0);
        chk("R9 idle no data", rvalid, 0);
        chk("R9 idle busy", busy, 0);
    endtask

    task automatic t_engage();
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R3 armed not busy", busy, 0);
        send_frame(8'hAA, 8'h55, 0);
        chk("R3 busy at boundary", busy, 1);
        chk("R3 lead frame dropped", rvalid, 0);
        send_frame(8'h81, 8'h3C, 0);
        pop_expect("R2 left", 8'h81, 0);
        pop_expect("R2 right", 8'h3C, 1);
        @(negedge clk); pop = 1'b1; @(negedge clk); pop = 1'b0;
        chk("R11 pop empty", rvalid, 0);
        send_frame(8'h01, 8'hFE, 0);
        pop_expect("R11 left after empty pop", 8'h01, 0);
        pop_expect("R11 right after empty pop", 8'hFE, 1);
    endtask

    task automatic t_overflow();
        send_frame(8'h11, 8'h12, 0);
        send_frame(8'h21, 8'h22, 0);
        chk("R4 full no ovf", oflag, 0);
        send_frame(8'h31, 8'h32, 0);
        chk("R5 ovf set", oflag, 1);
        chk("R6 irq", irq, 1);
        chk("R6 one edge", irq_rises, 1);
        send_frame(8'h41, 8'h42, 0);
        chk("R6 no second edge", irq_rises, 1);
        chk("R5 ovf sticky", oflag, 1);
        pop_expect("R4 kept left", 8'h11, 0);
        pop_expect("R4 kept right", 8'h12, 1);
        send_frame(8'h51, 8'h52, 0);
        pop_expect("R5 pair2 left", 8'h21, 0);
        pop_expect("R5 pair2 right", 8'h22, 1);
        pop_expect("R7 resumed left", 8'h51, 0);
        pop_expect("R7 resumed right", 8'h52, 1);
        @(negedge clk);
        chk("R5 dropped frames absent", rvalid, 0);
        pulse_oclr();
        chk("R7 flag cleared", oflag, 0);
        chk("R7 irq cleared", irq, 0);
    endtask

    task automatic t_mask();
        mask = 1'b1;
        send_frame(8'h61, 8'h62, 0);
        send_frame(8'h63, 8'h64, 0);
        send_frame(8'h65, 8'h66, 0);
        chk("R6 masked flag", oflag, 1);
        chk("R6 masked irq", irq, 0);
        @(negedge clk); mask = 1'b0;
        @(negedge clk);
        chk("R6 unmasked irq", irq, 1);
        pulse_oclr();
        pop_expect("R4 drain a", 8'h61, 0);
        pop_expect("R4 drain b", 8'h62, 1);
        pop_expect("R4 drain c", 8'h63, 0);
        pop_expect("R4 drain d", 8'h64, 1);
    endtask

    task automatic t_stop_clear();
        send_frame(8'h71, 8'h72, 0);
        pulse_fclr();
        chk("R10 clear ignored busy", rvalid, 1);
        send_frame(8'h73, 8'h74, 1);
        chk("R8 busy falls", busy, 0);
        send_frame(8'h75, 8'h76, 0);
        pop_expect("R10 kept left", 8'h71, 0);
        pop_expect("R10 kept right", 8'h72, 1);
        pop_expect("R8 last frame left", 8'h73, 0);
        @(negedge clk);
        chk("R8 right still held", rvalid, 1);
        pulse_fclr();
        chk("R10 cleared idle", rvalid, 0);
        chk("R9 after stop", busy, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_engage();
        t_overflow();
        t_mask();
        t_stop_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule